// File: doc/BRIEF.md
# SCSI Controller Programmed-I/O Register Port

This block is the byte-wide register window of a SCSI protocol controller when the host moves data by programmed I/O. Sixteen byte registers are picked by a four-bit register index taken from the byte address. Two of them hold a 16-bit transfer count. One is a data port backed by a small buffer with separate read and write pointers and an occupancy counter. One is a command register that records whether the next operation uses DMA or PIO and passes the 7-bit command code on as a one-cycle strobe. The rest are plain readable scratch registers or are unused.

The host fills the buffer by writing the data port, or it issues a transfer-information command in PIO mode. That command loads the occupancy counter straight from the transfer count and rewinds both pointers, so the host can then read back bytes that were placed in the buffer earlier. Each byte consumed from the data port raises a one-cycle interrupt pulse. Whenever the buffer drains, both pointers return to zero, so the next fill starts at entry 0. The phase sequencer, the DMA datapath and the storage side sit outside this block.

Top module: `spc_pio_regs`

## Requirements
- R1: The register index is the 4-bit `bus_addr` (byte address bits 5 to 2). Read data is registered: it appears on `rd_data` in the cycle after `rd_en`. After reset every register, the counter, both pointers and every flag are zero. Indices 4 to 7, 9 and 10 read as zero.
- R2: Index 0 holds the low byte and index 1 the high byte of the transfer count. Each reads back the last byte written to it.
- R3: A write to index 2 while fewer than DEPTH bytes are held stores the byte at the write pointer, advances it and adds one to the count. Bytes come back out in the order they were written.
- R4: A read of index 2 with a nonzero count returns the byte at the read pointer, advances it, lowers the count by one and pulses `irq` high for the one cycle after the read.
- R5: A read of index 2 with a zero count returns the byte most recently taken from the buffer, leaves the count at zero and raises no `irq`.
- R6: Whenever the count becomes zero, both pointers are zero, so the next byte written lands in entry 0.
- R7: A write to index 3 stores the byte for read-back, drives `dma_mode` from bit 7 and `cmd_code` from bits 6 to 0, and pulses `cmd_strobe` for one cycle.
- R8: Indices 8 and 11 to 15 read back the last byte written to them. Writes to indices 9 and 10 are ignored.
- R9: Command code 0x10 with bit 7 clear loads the count from the transfer count, capped at DEPTH, and clears both pointers. With bit 7 set, it leaves the buffer state unchanged.
- R10: A write to index 2 while DEPTH bytes are held is dropped and sets `fifo_ovf`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register index (byte address bits 5 to 2) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | One-cycle pulse for each byte taken from the data port |
| dma_mode | output | 1 | DMA flag from bit 7 of the last command |
| cmd_strobe | output | 1 | One-cycle pulse after a command write |
| cmd_code | output | 7 | Code of the last command |
| fifo_ovf | output | 1 | Sticky flag for a dropped data-port write |

## Verification
On every cycle the assertions check four things: the interrupt pulse and count step for each byte taken, a silent empty read, the invariant that an empty buffer has both pointers at zero, and the command strobe, code and mode flag after each command write. They also check overflow and that the overflow flag stays set. The bench scenarios are needed for the rest. Only they show that bytes leave the buffer in write order. Only they show the command path: the PIO transfer-information load, its cap at DEPTH, and its rewind to bytes written long before, while the DMA form leaves the buffer alone. The drain-to-zero rewind is shown only as data, through a later load that must find the newest byte in entry 0.

// File: rtl/spc_pio_pkg.sv
package spc_pio_pkg;

    localparam int IDX_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [IDX_W-1:0] IX_TC_LO = 4'd0;
    localparam logic [IDX_W-1:0] IX_TC_HI = 4'd1;
    localparam logic [IDX_W-1:0] IX_DATA  = 4'd2;
    localparam logic [IDX_W-1:0] IX_CMD   = 4'd3;

    localparam logic [6:0] OP_XFER_INFO = 7'h10;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    // scratch registers that keep their written value
    function automatic logic keeps_value(input logic [IDX_W-1:0] idx);
        return (idx == 4'd8) || (idx >= 4'd11);
    endfunction

endpackage

// File: rtl/spc_pio_fifo.sv
module spc_pio_fifo
    import spc_pio_pkg::*;
#(
    parameter int PTR_W = 4,
    localparam int DEPTH = 1 << PTR_W,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic              load_en,
    input  logic [15:0]       load_val,
    output logic [BYTE_W-1:0] out_byte,
    output logic              pop_done,
    output logic [CNT_W-1:0]  fill,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  wptr,
    output logic              ovf
);

    logic [BYTE_W-1:0] store [DEPTH];
    logic [BYTE_W-1:0] last_q;
    logic              full, empty, do_push;
    logic [CNT_W-1:0]  fill_nxt, load_cnt;

    assign full     = (fill == CNT_W'(DEPTH));
    assign empty    = (fill == '0);
    assign do_push  = push_req && !full && !load_en;
    assign pop_done = pop_req && !empty && !load_en;
    assign fill_nxt = fill + CNT_W'(do_push) - CNT_W'(pop_done);
    assign load_cnt = (load_val > 16'(DEPTH)) ? CNT_W'(DEPTH) : load_val[CNT_W-1:0];
    assign out_byte = pop_done ? store[rptr] : last_q;

    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            rptr   <= '0;
            wptr   <= '0;
            ovf    <= 1'b0;
            last_q <= '0;
        end else begin
            if (push_req && full) ovf <= 1'b1;
            if (pop_done) last_q <= store[rptr];
            if (load_en) begin
                fill <= load_cnt;
                rptr <= '0;
                wptr <= '0;
            end else begin
                fill <= fill_nxt;
                if (fill_nxt == '0) begin
                    rptr <= '0;
                    wptr <= '0;
                end else begin
                    if (pop_done) rptr <= rptr + 1'b1;
                    if (do_push)  wptr <= wptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spc_pio_regbank.sv
module spc_pio_regbank
    import spc_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [15:0]       xfer_len,
    output logic [BYTE_W-1:0] rd_val,
    output logic              dma_mode,
    output logic              cmd_strobe,
    output logic [6:0]        cmd_code
);

    logic [BYTE_W-1:0] tc_lo_q, tc_hi_q, cmd_q;
    logic [BYTE_W-1:0] scr [8];

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_lo_q    <= '0;
            tc_hi_q    <= '0;
            cmd_q      <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            cmd_strobe <= req.wr && (req.idx == IX_CMD);
            if (req.wr && req.idx == IX_TC_LO) tc_lo_q <= req.data;
            if (req.wr && req.idx == IX_TC_HI) tc_hi_q <= req.data;
            if (req.wr && req.idx == IX_CMD)   cmd_q   <= req.data;
        end
    end

    for (genvar g = 0; g < 8; g++) begin : g_scr
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(8 + g);
        if (keeps_value(MY_IDX)) begin : g_keep
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else if (req.wr && req.idx == MY_IDX) q <= req.data;
            end
            assign scr[g] = q;
        end else begin : g_void
            assign scr[g] = '0;
        end
    end

    always_comb begin
        unique case (req.idx)
            IX_TC_LO: rd_val = tc_lo_q;
            IX_TC_HI: rd_val = tc_hi_q;
            IX_CMD:   rd_val = cmd_q;
            default:  rd_val = req.idx[3] ? scr[req.idx[2:0]] : '0;
        endcase
    end

    assign xfer_len = {tc_hi_q, tc_lo_q};
    assign dma_mode = cmd_q[7];
    assign cmd_code = cmd_q[6:0];

endmodule

// File: rtl/spc_pio_regs.sv
module spc_pio_regs
    import spc_pio_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              dma_mode,
    output logic              cmd_strobe,
    output logic [6:0]        cmd_code,
    output logic              fifo_ovf
);

    localparam int CNT_W = PTR_W + 1;

    bus_req_t          req;
    logic [15:0]       xfer_len;
    logic [BYTE_W-1:0] bank_val, fifo_val;
    logic              pop_done, ti_load;
    logic [CNT_W-1:0]  fill_cnt;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;

    assign req = '{wr: wr_en, rd: rd_en, idx: bus_addr, data: wr_data};
    assign ti_load = req.wr && req.idx == IX_CMD && !req.data[7] && req.data[6:0] == OP_XFER_INFO;

    spc_pio_regbank u_bank (
        .clk(clk), .rst(rst), .req(req), .xfer_len(xfer_len), .rd_val(bank_val),
        .dma_mode(dma_mode), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    spc_pio_fifo #(.PTR_W(PTR_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push_req(req.wr && req.idx == IX_DATA),
        .pop_req(req.rd && req.idx == IX_DATA),
        .push_byte(req.data), .load_en(ti_load), .load_val(xfer_len),
        .out_byte(fifo_val), .pop_done(pop_done), .fill(fill_cnt),
        .rptr(rd_ptr), .wptr(wr_ptr), .ovf(fifo_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= pop_done;
            if (req.rd) rd_data <= (req.idx == IX_DATA) ? fifo_val : bank_val;
        end
    end

endmodule

// File: rtl/spc_pio_checker.sv
module spc_pio_checker #(
    parameter int PTR_W = 4,
    localparam int DEPTH = 1 << PTR_W,
    localparam int CNT_W = PTR_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             rd_en,
    input logic             irq,
    input logic             dma_mode,
    input logic             cmd_strobe,
    input logic [6:0]       cmd_code,
    input logic             fifo_ovf,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr
);

    assert_pop_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && bus_addr == 4'd2 && fill_cnt != '0)
        |=> (irq && fill_cnt == CNT_W'($past(fill_cnt) - 1'b1)));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && bus_addr == 4'd2 && fill_cnt == '0)
        |=> (!irq && fill_cnt == '0));

    assert_drained_ptrs_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == '0) |-> (rd_ptr == '0 && wr_ptr == '0));

    assert_cmd_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'd3)
        |=> (cmd_strobe && dma_mode == $past(wr_data[7]) && cmd_code == $past(wr_data[6:0])));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && bus_addr == 4'd2 && fill_cnt == CNT_W'(DEPTH))
        |=> (fifo_ovf && fill_cnt == CNT_W'(DEPTH)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_ovf |=> fifo_ovf);

endmodule

bind spc_pio_regs spc_pio_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .irq(irq), .dma_mode(dma_mode), .cmd_strobe(cmd_strobe),
    .cmd_code(cmd_code), .fifo_ovf(fifo_ovf), .fill_cnt(fill_cnt),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/spc_pio_regs_bench.sv
module spc_pio_regs_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq, dma_mode, cmd_strobe, fifo_ovf;
    logic [6:0] cmd_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spc_pio_regs u_spc_pio_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .dma_mode(dma_mode),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .fifo_ovf(fifo_ovf)
    );

    // {is_read, req number, index, write data, expected read}
    localparam int NV = 22;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 4'd1,  4'd0,  8'h00, 8'h00},  // R1 reset value
        {1'b0, 4'd2,  4'd0,  8'h34, 8'h00},  // R2
        {1'b0, 4'd2,  4'd1,  8'h12, 8'h00},
        {1'b1, 4'd2,  4'd0,  8'h00, 8'h34},
        {1'b1, 4'd2,  4'd1,  8'h00, 8'h12},
        {1'b0, 4'd8,  4'd8,  8'hA5, 8'h00},  // R8
        {1'b1, 4'd8,  4'd8,  8'h00, 8'hA5},
        {1'b0, 4'd8,  4'd11, 8'h5A, 8'h00},
        {1'b1, 4'd8,  4'd11, 8'h00, 8'h5A},
        {1'b0, 4'd8,  4'd15, 8'hC3, 8'h00},
        {1'b1, 4'd8,  4'd15, 8'h00, 8'hC3},
        {1'b0, 4'd8,  4'd9,  8'hFF, 8'h00},
        {1'b1, 4'd8,  4'd9,  8'h00, 8'h00},
        {1'b0, 4'd8,  4'd10, 8'h77, 8'h00},
        {1'b1, 4'd8,  4'd10, 8'h00, 8'h00},
        {1'b1, 4'd1,  4'd5,  8'h00, 8'h00},  // R1 unused index
        {1'b0, 4'd3,  4'd2,  8'h11, 8'h00},  // R3
        {1'b0, 4'd3,  4'd2,  8'h22, 8'h00},
        {1'b1, 4'd3,  4'd2,  8'h00, 8'h11},
        {1'b1, 4'd3,  4'd2,  8'h00, 8'h22},
        {1'b1, 4'd5,  4'd2,  8'h00, 8'h22},  // R5 empty read
        {1'b1, 4'd7,  4'd3,  8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_addr = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = idx; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 ovf", {7'd0, fifo_ovf}, 8'h00);
        check("R1 dma", {7'd0, dma_mode}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                do_rd(VEC[i][19:16], v);
                check($sformatf("R%0d vec%0d", VEC[i][23:20], i), v, VEC[i][7:0]);
            end else begin
                do_wr(VEC[i][19:16], VEC[i][15:8]);
            end
        end

        // R4 interrupt pulse, R5 no pulse on empty
        do_wr(4'd2, 8'h44);
        do_rd(4'd2, v);
        check("R4 data", v, 8'h44);
        check("R4 irq", {7'd0, irq}, 8'h01);
        do_rd(4'd2, v);
        check("R5 data", v, 8'h44);
        check("R5 irq", {7'd0, irq}, 8'h00);

        // R10 overflow drop
        for (int i = 0; i < 17; i++) do_wr(4'd2, 8'h80 + 8'(i));
        check("R10 ovf", {7'd0, fifo_ovf}, 8'h01);
        for (int i = 0; i < 17; i++) begin
            do_rd(4'd2, v);
            check("R10 order", v, (i < 16) ? 8'h80 + 8'(i) : 8'h8F);
        end
        check("R10 sticky", {7'd0, fifo_ovf}, 8'h01);

        // R9 load capped at depth, R7 command outputs
        do_wr(4'd0, 8'h00);
        do_wr(4'd1, 8'h01);
        do_wr(4'd3, 8'h10);
        check("R7 strobe", {7'd0, cmd_strobe}, 8'h01);
        check("R7 code", {1'b0, cmd_code}, 8'h10);
        check("R7 dma", {7'd0, dma_mode}, 8'h00);
        for (int i = 0; i < 17; i++) begin
            do_rd(4'd2, v);
            check("R9 cap", v, (i < 16) ? 8'h80 + 8'(i) : 8'h8F);
        end

        // R6 drain rewinds pointers
        do_wr(4'd2, 8'hA1); do_wr(4'd2, 8'hA2); do_wr(4'd2, 8'hA3);
        for (int i = 0; i < 3; i++) do_rd(4'd2, v);
        check("R6 drain", v, 8'hA3);
        do_wr(4'd2, 8'hD0);
        do_wr(4'd0, 8'h01);
        do_wr(4'd1, 8'h00);
        do_wr(4'd3, 8'h10);
        do_rd(4'd2, v);
        check("R6 entry0", v, 8'hD0);
        do_rd(4'd2, v);
        check("R6 empty", v, 8'hD0);

        // R9 DMA form leaves the buffer alone
        do_wr(4'd2, 8'hE5);
        do_wr(4'd0, 8'h05);
        do_wr(4'd3, 8'h90);
        check("R7 dma set", {7'd0, dma_mode}, 8'h01);
        do_rd(4'd2, v);
        check("R9 dma first", v, 8'hE5);
        do_rd(4'd2, v);
        check("R9 dma no load", v, 8'hE5);
        do_rd(4'd3, v);
        check("R7 readback", v, 8'h90);
        @(negedge clk);
        check("R7 strobe low", {7'd0, cmd_strobe}, 8'h00);

        finish_run();
    end

endmodule